// File: doc/BRIEF.md
# Variable-Length Message Receive FIFO

This block buffers received CAN frames between the bit-level receiver and the host. Every frame is kept as a two-byte descriptor (identifier bits plus the RTR flag and the data length code) followed by zero to eight data bytes. All pending frames share one circular byte store of parameterised size, 64 bytes by default. A short frame therefore takes less room than a long one, and the number of frames that fit at once depends on their lengths.

The receiver drives the write side. It pulses `wrStart` to open a frame, then gives one byte per `wrValid` cycle, and ends the frame with either `wrCommit` (the frame was received correctly) or `wrAbort` (the frame had an error). The host drives the read side. It reads the oldest committed frame through a ten-slot window addressed by `winAddr`, and pulses `relCmd` to free that frame so that the next one moves into the window. Status outputs report whether a frame is waiting, how many are stored, and whether data overrun occurred. Two interrupt lines follow from these, each gated by its own enable.

Top module: `rxq_fifo`

## Requirements
- R1: After reset the store is empty. `msgCount` is 0, `rxReady`, `ovrStatus`, `rxIrq` and `ovrIrq` are 0, and every window slot reads 0.
- R2: A frame's length is 2 plus its data length code, where the code is bits 3:0 of the second descriptor byte and any value above 8 counts as 8. While a frame is present, window slot i (0 to 9) shows byte i of the oldest frame. Slot 0 is the first descriptor byte, slot 1 is the second, and slots 2 onward are data. Slots at or beyond the frame's length read 0.
- R3: Committed frames lie back to back in the shared store and wrap around its end. Any mix of lengths whose total does not exceed DEPTH is held at the same time.
- R4: If a frame is longer than the free space (DEPTH minus the bytes held by committed frames), it is dropped. Its partly written bytes are rolled back, so the frames already stored and the position where the next frame goes are not changed.
- R5: Data overrun is raised only when a dropped frame is committed. A dropped frame that ends with `wrAbort` sets no flag.
- R6: Each valid commit increments `msgCount`. `rxReady` is high whenever `msgCount` is nonzero, and `rxIrq` is `rxReady` gated by `rxIntEn`.
- R7: An overrun sets `ovrStatus`. In the same cycle it also sets `ovrIrq` if `ovrIntEn` is high. A `clrOvr` pulse clears both.
- R8: `relCmd` frees the oldest frame, and the next stored frame appears in the window. A release given while `msgCount` is 0 has no effect on the count, the window or later frames.
- R9: A frame closed by `wrAbort` is discarded. So is a frame cut short by a new `wrStart`, and a frame committed with fewer bytes than its length. None of these changes the count or the flags.
- R10: Bytes delivered beyond a frame's length are ignored. They do not reach the store and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStart | input | 1 | Opens a new frame and discards any frame in progress |
| wrValid | input | 1 | `wrByte` carries the next frame byte |
| wrByte | input | 8 | Received byte |
| wrCommit | input | 1 | Frame received correctly, store it |
| wrAbort | input | 1 | Frame in error, discard it |
| relCmd | input | 1 | Release the oldest frame |
| clrOvr | input | 1 | Clear the overrun status and overrun interrupt |
| rxIntEn | input | 1 | Receive interrupt enable |
| ovrIntEn | input | 1 | Overrun interrupt enable |
| winAddr | input | 4 | Window slot, 0 to 9 |
| winData | output | 8 | Byte at the addressed slot of the oldest frame |
| rxReady | output | 1 | At least one frame is stored |
| msgCount | output | CW | Number of committed frames |
| ovrStatus | output | 1 | Data overrun occurred |
| rxIrq | output | 1 | Receive interrupt |
| ovrIrq | output | 1 | Overrun interrupt |

## Verification
The bench fills the store to exactly its capacity with a mix of lengths. It then offers a frame one size too large, once aborted and once committed. A design that checks space byte by byte instead of against the whole length would store a truncated frame or overwrite the oldest one, and a design that flags overrun at the moment of the drop would raise it on the aborted frame as well. After some releases, frames are written across the end of the store and read back in order. This exposes pointer arithmetic that fails to wrap or that advances by the wrong length. Further cases cover a data length code of 15 sent with surplus bytes, a release on an empty store, a frame restarted in mid-flight, and a commit with too few bytes. Each of these would leave the head pointer or the count shifted in a design that handled it wrong.

// File: rtl/rxq_pkg.sv
`timescale 1ns/10ps
package rxq_pkg;
  localparam int DESC_BYTES = 2;
  localparam int MAX_DATA   = 8;
  localparam int WIN_SLOTS  = DESC_BYTES + MAX_DATA;

  // Strobes from control to the byte store.
  typedef struct packed {
    logic       writeEn;
    logic [7:0] writeByte;
  } storeCmd_t;

  // Frame length from the second descriptor byte: 2 + min(code, 8).
  function automatic logic [3:0] msgLen(input logic [7:0] desc2);
    logic [3:0] code;
    code = desc2[3:0];
    if (code > 4'(MAX_DATA)) return 4'(WIN_SLOTS);
    return code + 4'(DESC_BYTES);
  endfunction
endpackage

// File: rtl/rxq_ctrl.sv
`timescale 1ns/10ps
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrStart,
  input  logic          wrValid,
  input  logic [7:0]    wrByte,
  input  logic          wrCommit,
  input  logic          wrAbort,
  input  logic          relCmd,
  input  logic          clrOvr,
  input  logic          ovrIntEn,
  input  logic [3:0]    oldestLen,
  output storeCmd_t     cmd,
  output logic [AW-1:0] writeAddr,
  output logic [AW-1:0] headPtr,
  output logic          hasMsg,
  output logic [CW-1:0] msgCount,
  output logic          ovrFlag,
  output logic          ovrIrq
);
  logic [AW-1:0] tailPtr;
  logic [CW-1:0] usedBytes;
  logic [3:0]    byteIdx, byteIdxN;
  logic [3:0]    curLen, curLenN;
  logic          inFrame, inFrameN;
  logic          dropping, droppingN;
  logic [3:0]    addLen;
  logic          addMsg, setOvr, doRel;
  logic [3:0]    newLen;
  logic [CW-1:0] freeBytes;
  logic          fitsFirst, fitsWhole;

  assign newLen    = msgLen(wrByte);
  assign freeBytes = CW'(DEPTH) - usedBytes;
  assign fitsFirst = usedBytes < CW'(DEPTH);
  assign fitsWhole = CW'(newLen) <= freeBytes;
  assign writeAddr = tailPtr + AW'(byteIdx);
  assign doRel     = relCmd && (msgCount != '0);
  assign hasMsg    = msgCount != '0;

  // Write-side sequencing: accept, drop or finish the frame in progress.
  always_comb begin
    cmd       = '0;
    byteIdxN  = byteIdx;
    curLenN   = curLen;
    inFrameN  = inFrame;
    droppingN = dropping;
    addLen    = '0;
    addMsg    = 1'b0;
    setOvr    = 1'b0;
    if (wrStart) begin
      inFrameN  = 1'b1;
      droppingN = 1'b0;
      byteIdxN  = '0;
      curLenN   = '0;
    end else if (wrAbort) begin
      inFrameN = 1'b0;
    end else if (wrCommit && inFrame) begin
      inFrameN = 1'b0;
      if (dropping) begin
        setOvr = 1'b1;
      end else if (byteIdx >= 4'(DESC_BYTES) && byteIdx == curLen) begin
        addLen = curLen;
        addMsg = 1'b1;
      end
    end else if (wrValid && inFrame && !dropping) begin
      if (byteIdx == 4'd0) begin
        if (fitsFirst) begin
          cmd.writeEn   = 1'b1;
          cmd.writeByte = wrByte;
          byteIdxN      = byteIdx + 4'd1;
        end else begin
          droppingN = 1'b1;
        end
      end else if (byteIdx == 4'd1) begin
        if (fitsWhole) begin
          cmd.writeEn   = 1'b1;
          cmd.writeByte = wrByte;
          byteIdxN      = byteIdx + 4'd1;
          curLenN       = newLen;
        end else begin
          droppingN = 1'b1;
        end
      end else if (byteIdx < curLen) begin
        cmd.writeEn   = 1'b1;
        cmd.writeByte = wrByte;
        byteIdxN      = byteIdx + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx  <= '0;
      curLen   <= '0;
      inFrame  <= 1'b0;
      dropping <= 1'b0;
    end else begin
      byteIdx  <= byteIdxN;
      curLen   <= curLenN;
      inFrame  <= inFrameN;
      dropping <= droppingN;
    end
  end

  // Occupancy and pointers; commit and release may meet in one cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailPtr   <= '0;
      headPtr   <= '0;
      usedBytes <= '0;
      msgCount  <= '0;
    end else begin
      tailPtr   <= tailPtr + AW'(addLen);
      if (doRel) headPtr <= headPtr + AW'(oldestLen);
      usedBytes <= usedBytes + CW'(addLen) - (doRel ? CW'(oldestLen) : CW'(0));
      msgCount  <= msgCount + CW'(addMsg) - CW'(doRel);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrFlag <= 1'b0;
      ovrIrq  <= 1'b0;
    end else begin
      if (setOvr) begin
        ovrFlag <= 1'b1;
        if (ovrIntEn) ovrIrq <= 1'b1;
      end else if (clrOvr) begin
        ovrFlag <= 1'b0;
        ovrIrq  <= 1'b0;
      end
    end
  end

  assert_used_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    usedBytes <= CW'(DEPTH));
  assert_count_agrees_R6: assert property (@(posedge clk) disable iff (!rstN)
    (msgCount == '0) == (usedBytes == '0));
  assert_empty_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (relCmd && msgCount == '0) |=> $stable(headPtr));
  assert_ovr_from_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(wrCommit));
  assert_drop_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    dropping |-> !cmd.writeEn);
endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/10ps
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  storeCmd_t     cmd,
  input  logic [AW-1:0] writeAddr,
  input  logic [AW-1:0] headPtr,
  input  logic          hasMsg,
  input  logic [3:0]    winAddr,
  output logic [7:0]    winData,
  output logic [3:0]    oldestLen
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] readAddr;
  logic [AW-1:0] descAddr;

  for (genvar g = 0; g < DEPTH; g++) begin : gCell
    always_ff @(posedge clk) begin
      if (cmd.writeEn && writeAddr == AW'(g)) mem[g] <= cmd.writeByte;
    end
  end

  assign descAddr  = headPtr + AW'(1);
  assign oldestLen = msgLen(mem[descAddr]);
  assign readAddr  = headPtr + AW'(winAddr);
  assign winData   = (hasMsg && winAddr < oldestLen) ? mem[readAddr] : 8'h00;

  assert_len_range_R2: assert property (@(posedge clk)
    hasMsg |-> (oldestLen >= 4'(DESC_BYTES) && oldestLen <= 4'(WIN_SLOTS)));
endmodule

// File: rtl/rxq_fifo.sv
`timescale 1ns/10ps
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrStart,
  input  logic          wrValid,
  input  logic [7:0]    wrByte,
  input  logic          wrCommit,
  input  logic          wrAbort,
  input  logic          relCmd,
  input  logic          clrOvr,
  input  logic          rxIntEn,
  input  logic          ovrIntEn,
  input  logic [3:0]    winAddr,
  output logic [7:0]    winData,
  output logic          rxReady,
  output logic [CW-1:0] msgCount,
  output logic          ovrStatus,
  output logic          rxIrq,
  output logic          ovrIrq
);
  storeCmd_t     cmd;
  logic [AW-1:0] writeAddr, headPtr;
  logic          hasMsg;
  logic [3:0]    oldestLen;

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrValid(wrValid),
    .wrByte(wrByte), .wrCommit(wrCommit), .wrAbort(wrAbort),
    .relCmd(relCmd), .clrOvr(clrOvr), .ovrIntEn(ovrIntEn),
    .oldestLen(oldestLen), .cmd(cmd), .writeAddr(writeAddr),
    .headPtr(headPtr), .hasMsg(hasMsg), .msgCount(msgCount),
    .ovrFlag(ovrStatus), .ovrIrq(ovrIrq)
  );

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .cmd(cmd), .writeAddr(writeAddr), .headPtr(headPtr),
    .hasMsg(hasMsg), .winAddr(winAddr), .winData(winData),
    .oldestLen(oldestLen)
  );

  assign rxReady = hasMsg;
  assign rxIrq   = rxIntEn & hasMsg;

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    ovrIrq |-> ovrStatus);
endmodule

// File: tb/rxq_fifo_tb.sv
`timescale 1ns/10ps
module rxq_fifo_tb_top;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStart = 0, wrValid = 0, wrCommit = 0, wrAbort = 0;
  logic relCmd = 0, clrOvr = 0, rxIntEn = 0, ovrIntEn = 0;
  logic [7:0] wrByte = 0;
  logic [3:0] winAddr = 0;
  logic [7:0] winData;
  logic rxReady, ovrStatus, rxIrq, ovrIrq;
  logic [CW-1:0] msgCount;

  always #4 clk = ~clk;  // 125 MHz

  rxq_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrValid(wrValid),
    .wrByte(wrByte), .wrCommit(wrCommit), .wrAbort(wrAbort),
    .relCmd(relCmd), .clrOvr(clrOvr), .rxIntEn(rxIntEn), .ovrIntEn(ovrIntEn),
    .winAddr(winAddr), .winData(winData), .rxReady(rxReady),
    .msgCount(msgCount), .ovrStatus(ovrStatus), .rxIrq(rxIrq), .ovrIrq(ovrIrq)
  );

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] mdl[$];
  int mlen[$];
  int used = 0;
  bit expOvr = 0, expOvrIrq = 0;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkStatus(input string req);
    chk({req, " count"}, int'(msgCount), mlen.size());
    chk({req, " rxReady"}, int'(rxReady), int'(mlen.size() > 0));
    chk({req, " rxIrq"}, int'(rxIrq), int'(rxIntEn && mlen.size() > 0));
    chk({req, " ovrStatus"}, int'(ovrStatus), int'(expOvr));
    chk({req, " ovrIrq"}, int'(ovrIrq), int'(expOvrIrq));
  endtask

  task automatic checkHead(input string req);
    for (int s = 0; s < 10; s++) begin
      int exp;
      winAddr = 4'(s);
      #0.2;
      exp = (mlen.size() > 0 && s < mlen[0]) ? int'(mdl[s]) : 0;
      chk({req, " window"}, int'(winData), exp);
    end
    winAddr = 0;
  endtask

  task automatic sendFrame(input logic [7:0] b0, input logic [7:0] b1,
                           input int nData, input int seed, input bit doCommit);
    int len;
    logic [7:0] bytes[$];
    len = 2 + ((b1[3:0] > 8) ? 8 : int'(b1[3:0]));
    bytes.push_back(b0);
    bytes.push_back(b1);
    for (int k = 0; k < nData; k++) bytes.push_back(8'(seed + k));
    @(negedge clk) wrStart = 1;
    @(negedge clk) wrStart = 0;
    for (int k = 0; k < bytes.size(); k++) begin
      wrValid = 1; wrByte = bytes[k];
      @(negedge clk);
    end
    wrValid = 0;
    if (doCommit) wrCommit = 1; else wrAbort = 1;
    @(negedge clk) wrCommit = 0; wrAbort = 0;
    if (doCommit) begin
      if (len > DEPTH - used) begin
        expOvr = 1;
        if (ovrIntEn) expOvrIrq = 1;
      end else if (bytes.size() >= len) begin
        for (int k = 0; k < len; k++) mdl.push_back(bytes[k]);
        mlen.push_back(len);
        used += len;
      end
    end
  endtask

  task automatic releaseHead();
    @(negedge clk) relCmd = 1;
    @(negedge clk) relCmd = 0;
    if (mlen.size() > 0) begin
      int len;
      len = mlen.pop_front();
      for (int k = 0; k < len; k++) void'(mdl.pop_front());
      used -= len;
    end
  endtask

  task automatic clearOverrun();
    @(negedge clk) clrOvr = 1;
    @(negedge clk) clrOvr = 0;
    expOvr = 0; expOvrIrq = 0;
  endtask

  task automatic testReset();
    checkStatus("R1");
    checkHead("R1");
  endtask

  task automatic testSingle();
    rxIntEn = 1;
    sendFrame(8'hA5, 8'h23, 3, 8'h10, 1);
    checkStatus("R6 single");
    checkHead("R2 single");
    rxIntEn = 0;
    #0.2;
    checkStatus("R6 irq gated");
    rxIntEn = 1;
  endtask

  task automatic testRelease();
    sendFrame(8'h11, 8'h01, 1, 8'h40, 1);
    releaseHead();
    checkHead("R8 next appears");
    checkStatus("R8 after release");
    releaseHead();
    releaseHead();
    releaseHead();
    checkStatus("R8 empty release");
    checkHead("R8 empty window");
    sendFrame(8'h22, 8'h05, 5, 8'h60, 1);
    checkHead("R8 head kept");
    releaseHead();
  endtask

  task automatic testLongCode();
    sendFrame(8'h3C, 8'h4F, 11, 8'h80, 1);
    checkHead("R2 code 15");
    sendFrame(8'h3D, 8'h02, 2, 8'hC0, 1);
    releaseHead();
    checkHead("R10 surplus ignored");
    releaseHead();
    checkStatus("R10 drained");
  endtask

  task automatic testDiscard();
    sendFrame(8'h55, 8'h04, 4, 8'h20, 0);
    checkStatus("R9 abort");
    sendFrame(8'h56, 8'h06, 3, 8'h20, 1);
    checkStatus("R9 short commit");
    @(negedge clk) wrStart = 1;
    @(negedge clk) wrStart = 0; wrValid = 1; wrByte = 8'h99;
    @(negedge clk) wrByte = 8'h08;
    @(negedge clk) wrByte = 8'hEE;
    @(negedge clk) wrValid = 0;
    sendFrame(8'h57, 8'h02, 2, 8'h30, 1);
    checkHead("R9 restart");
    checkStatus("R9 restart count");
    releaseHead();
  endtask

  task automatic testFill();
    ovrIntEn = 1;
    for (int m = 0; m < 6; m++) sendFrame(8'(m), 8'h08, 8, 16 * m, 1);
    checkStatus("R3 sixty bytes");
    sendFrame(8'h70, 8'h03, 3, 8'h01, 0);
    checkStatus("R5 dropped abort");
    sendFrame(8'h71, 8'h03, 3, 8'h01, 1);
    checkStatus("R4 R7 overrun");
    checkHead("R4 head intact");
    sendFrame(8'h72, 8'h02, 2, 8'hA0, 1);
    checkStatus("R3 exact fill");
    clearOverrun();
    checkStatus("R7 cleared");
    releaseHead();
    releaseHead();
    sendFrame(8'h73, 8'h08, 8, 8'hD0, 1);
    sendFrame(8'h74, 8'h0A, 8, 8'hE0, 1);
    checkStatus("R3 wrapped");
    while (mlen.size() > 0) begin
      checkHead("R3 drain order");
      releaseHead();
    end
    checkStatus("R3 empty");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSingle();
    releaseHead();
    testRelease();
    testLongCode();
    testDiscard();
    testFill();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule